// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block deserialises two-channel audio arriving on three wires: a bit clock, a word clock that separates the two channel slots, and one data line. It runs entirely on the bit clock. The data line and the word clock are sampled on each rising bit-clock edge. For every stereo frame it presents one signed, sign-extended sample per channel, together with a single-cycle strobe once the right-channel sample of the pair is in.

Static control inputs select the framing style and the word length, and can swap which word-clock level means "left". The framing style is either right-justified, where the sample occupies the last bits before the slot closes, or I2S, where the sample starts one bit after the word-clock transition. The word length is 16, 20 or 24 bits.

A zero-run detector watches the data line. After a long unbroken run of zero bits it raises a flag. It also raises a request to force the analog path to zero, but only when that feature is enabled. The first nonzero bit clears both.

Top module: `serial_audio_rx`

## Requirements
- R1: Samples are two's complement, received MSB first, and are presented sign-extended to 24 bits on the left and right outputs.
- R2: The 2-bit word-length input selects 16 bits for code 00, 20 bits for 01 and 24 bits for 10; the reserved code 11 behaves exactly like 24 bits.
- R3: In right-justified framing (format input low), the sample of a slot is the last N bits captured before the word-clock edge that ends the slot (N the selected length); any earlier bits in the slot are discarded.
- R4: In I2S framing (format input high), the MSB is the bit captured one bit clock after the word-clock transition, and the following N-1 bits complete the sample; later bits in the slot are ignored.
- R5: With the swap input low, a high word clock marks the left slot and a low word clock the right slot; with the swap input high the assignment is reversed.
- R6: The pair-valid output pulses high for exactly one clock per frame, after the right sample completes; the right output only changes together with that pulse.
- R7: The zero flag rises once the data line has been sampled zero on ZERO_RUN consecutive bit clocks (65,536 by default), and not after ZERO_RUN-1.
- R8: The force-to-zero request follows the zero flag only while the zero-detect enable input is high, and is low whenever it is low.
- R9: Any nonzero data bit clears the zero-run count and drops the flag and request; the count saturates at ZERO_RUN.
- R10: Synchronous active-high reset clears both samples, the pair-valid strobe, the zero flag and the force request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Word clock marking the channel slots |
| sdata_i | input | 1 | Serial audio data, MSB first |
| cfg_i2s_i | input | 1 | Framing: 0 right-justified, 1 I2S |
| cfg_wlen_i | input | 2 | Word length: 00=16, 01=20, 10=24, 11=24 |
| cfg_lr_swap_i | input | 1 | 0: high word clock is left; 1: high is right |
| cfg_zdet_en_i | input | 1 | Enables the force-to-zero request |
| left_o | output | SAMPLE_W | Sign-extended left sample |
| right_o | output | SAMPLE_W | Sign-extended right sample |
| pair_valid_o | output | 1 | One-cycle strobe when a stereo pair is complete |
| zero_flag_o | output | 1 | Long zero run detected |
| force_zero_o | output | 1 | Request to force the output to zero |

## Verification
The bench keeps the default 24-bit sample path and the 16/20 short lengths. It sets ZERO_RUN to 64, so the exact threshold, the one-bit-short case, saturation and clearing of the zero-run counter can all be exercised many times within a short run. Slot lengths of exactly N, N+1 and well above N, filled with ones around the sample, make the right-justified discard and the I2S one-bit offset visible at the sample outputs.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // word-length selection codes; the reserved code is decoded as the longest length
  typedef enum logic [1:0] {
    WLEN_16  = 2'b00,
    WLEN_20  = 2'b01,
    WLEN_24  = 2'b10,
    WLEN_RSV = 2'b11
  } wlen_e;
endpackage

// File: rtl/sar_capture.sv
// Input capture on the rising bit-clock edge plus word-clock edge detection.
module sar_capture (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_o,
  output logic ws_o,
  output logic ws_prev_o,
  output logic live_o,
  output logic edge_o
);
  logic ws_q, sd_q, live_q;
  logic ws_p, live_p;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ws_q   <= 1'b0;
      sd_q   <= 1'b0;
      live_q <= 1'b0;
      ws_p   <= 1'b0;
      live_p <= 1'b0;
    end else begin
      ws_q   <= ws_i;
      sd_q   <= sd_i;
      live_q <= 1'b1;
      ws_p   <= ws_q;
      live_p <= live_q;
    end
  end

  assign bit_o     = sd_q;
  assign ws_o      = ws_q;
  assign ws_prev_o = ws_p;
  assign live_o    = live_q;
  // an edge only counts once two real samples of the word clock exist
  assign edge_o    = live_q & live_p & (ws_q ^ ws_p);
endmodule

// File: rtl/sar_assembler.sv
// Shared shift register and slot position counter; decides when a sample is
// complete for either framing style and sign-extends it.
module sar_assembler #(
  parameter int SAMPLE_W = 24,
  parameter int W_SHORT  = 16,
  parameter int W_MID    = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  bit_i,
  input  logic                  ws_i,
  input  logic                  ws_prev_i,
  input  logic                  live_i,
  input  logic                  edge_i,
  input  logic                  i2s_i,
  input  sar_pkg::wlen_e        wlen_i,
  input  logic                  swap_i,
  output logic                  take_o,
  output logic                  take_left_o,
  output logic [SAMPLE_W-1:0]   word_o
);
  localparam int POS_W = $clog2(SAMPLE_W + 2);

  logic [SAMPLE_W-1:0] shreg_q;
  logic [SAMPLE_W-1:0] raw;
  logic [POS_W-1:0]    pos_q, pos_cur, n_len;
  logic                sign_bit;

  always_comb begin
    case (wlen_i)
      sar_pkg::WLEN_16: n_len = POS_W'(W_SHORT);
      sar_pkg::WLEN_20: n_len = POS_W'(W_MID);
      default:          n_len = POS_W'(SAMPLE_W);
    endcase
  end

  // position of the bit now in the capture stage; 0 is the first bit of a slot
  assign pos_cur = edge_i ? '0 : pos_q;

  // right-justified: the register already holds the slot's last bits at the edge;
  // I2S: the current bit is the last of the word
  assign raw = i2s_i ? {shreg_q[SAMPLE_W-2:0], bit_i} : shreg_q;

  assign take_o      = i2s_i ? (live_i && (pos_cur == n_len)) : edge_i;
  assign take_left_o = i2s_i ? (ws_i ^ swap_i) : (ws_prev_i ^ swap_i);

  assign sign_bit = raw[n_len - 1'b1];

  for (genvar gi = 0; gi < SAMPLE_W; gi++) begin : g_sext
    assign word_o[gi] = (POS_W'(gi) < n_len) ? raw[gi] : sign_bit;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shreg_q <= '0;
      pos_q   <= '1;
    end else if (live_i) begin
      shreg_q <= {shreg_q[SAMPLE_W-2:0], bit_i};
      pos_q   <= (pos_cur == '1) ? pos_cur : pos_cur + 1'b1;
    end
  end
endmodule

// File: rtl/sar_zero_det.sv
// Saturating run-length counter of zero data bits.
module sar_zero_det #(
  parameter int RUN = 65536
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic live_i,
  input  logic bit_i,
  input  logic en_i,
  output logic flag_o,
  output logic force_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q, force_q;
  logic          hit;

  // this zero bit completes (or extends) a run of RUN zeros
  assign hit = (cnt_q >= CW'(RUN - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      force_q <= 1'b0;
    end else if (live_i) begin
      if (bit_i) begin
        cnt_q   <= '0;
        flag_q  <= 1'b0;
        force_q <= 1'b0;
      end else begin
        if (cnt_q != CW'(RUN)) cnt_q <= cnt_q + 1'b1;
        flag_q  <= hit;
        force_q <= hit & en_i;
      end
    end
  end

  assign flag_o  = flag_q;
  assign force_o = force_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 24,
  parameter int W_SHORT  = 16,
  parameter int W_MID    = 20,
  parameter int ZERO_RUN = 65536
) (
  input  logic                bclk_i,
  input  logic                rst_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic                cfg_i2s_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic                cfg_lr_swap_i,
  input  logic                cfg_zdet_en_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o,
  output logic                zero_flag_o,
  output logic                force_zero_o
);
  logic                bit_c, ws_c, ws_p, live_c, edge_c;
  logic                take, take_left;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] left_q, right_q;
  logic                valid_q;

  sar_capture cap_i (
    .clk_i    (bclk_i),
    .rst_i    (rst_i),
    .ws_i     (wclk_i),
    .sd_i     (sdata_i),
    .bit_o    (bit_c),
    .ws_o     (ws_c),
    .ws_prev_o(ws_p),
    .live_o   (live_c),
    .edge_o   (edge_c)
  );

  sar_assembler #(
    .SAMPLE_W(SAMPLE_W),
    .W_SHORT (W_SHORT),
    .W_MID   (W_MID)
  ) asm_i (
    .clk_i      (bclk_i),
    .rst_i      (rst_i),
    .bit_i      (bit_c),
    .ws_i       (ws_c),
    .ws_prev_i  (ws_p),
    .live_i     (live_c),
    .edge_i     (edge_c),
    .i2s_i      (cfg_i2s_i),
    .wlen_i     (sar_pkg::wlen_e'(cfg_wlen_i)),
    .swap_i     (cfg_lr_swap_i),
    .take_o     (take),
    .take_left_o(take_left),
    .word_o     (word)
  );

  sar_zero_det #(
    .RUN(ZERO_RUN)
  ) zdet_i (
    .clk_i  (bclk_i),
    .rst_i  (rst_i),
    .live_i (live_c),
    .bit_i  (bit_c),
    .en_i   (cfg_zdet_en_i),
    .flag_o (zero_flag_o),
    .force_o(force_zero_o)
  );

  always_ff @(posedge bclk_i) begin
    if (rst_i) begin
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (take) begin
        if (take_left) begin
          left_q <= word;
        end else begin
          right_q <= word;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign left_o       = left_q;
  assign right_o      = right_q;
  assign pair_valid_o = valid_q;
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 65536
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                sdata_i,
  input logic                zen_i,
  input logic                valid_i,
  input logic                flag_i,
  input logic                force_i,
  input logic [SAMPLE_W-1:0] left_i,
  input logic [SAMPLE_W-1:0] right_i
);
  localparam int CW = $clog2(ZERO_RUN + 1);

  logic [CW-1:0] zc;
  logic          rst_q;

  // independent count of consecutive zero samples seen on the data pin
  always_ff @(posedge clk_i) begin
    if (rst_i)                    zc <= '0;
    else if (sdata_i)             zc <= '0;
    else if (zc != CW'(ZERO_RUN)) zc <= zc + 1'b1;
  end

  always_ff @(posedge clk_i) rst_q <= rst_i;

  a_r6_valid_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |=> !valid_i);

  a_r6_right_moves_with_valid: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_i |-> $stable(right_i));

  a_r7_flag_needs_full_run: assert property (@(posedge clk_i) disable iff (rst_i)
    flag_i |-> ($past(zc) == CW'(ZERO_RUN)));

  a_r7_full_run_sets_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && ($past(zc) == CW'(ZERO_RUN))) |-> flag_i);

  a_r8_force_needs_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    force_i |-> flag_i);

  a_r8_force_when_enabled: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_i && $past(zen_i)) |-> force_i);

  a_r9_nonzero_drops_flag: assert property (@(posedge clk_i) disable iff (rst_i)
    sdata_i |-> ##2 !flag_i);

  always @(negedge clk_i) begin
    if (rst_q) begin
      a_r10_reset_state: assert (!valid_i && !flag_i && !force_i &&
                                 left_i == '0 && right_i == '0)
        else $error("R10 state not cleared by reset");
    end
  end
endmodule

bind serial_audio_rx serial_audio_rx_chk #(
  .SAMPLE_W(SAMPLE_W),
  .ZERO_RUN(ZERO_RUN)
) chk_i (
  .clk_i  (bclk_i),
  .rst_i  (rst_i),
  .sdata_i(sdata_i),
  .zen_i  (cfg_zdet_en_i),
  .valid_i(pair_valid_o),
  .flag_i (zero_flag_o),
  .force_i(force_zero_o),
  .left_i (left_o),
  .right_i(right_o)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  localparam int RUN = 64;
  localparam int NV  = 9;

  // {i2s, wlen[1:0], swap, slot[5:0], L, R, expected L, expected R}
  localparam logic [105:0] VEC [NV] = '{
    {1'b0, 2'b00, 1'b0, 6'd32, 24'h008001, 24'h007FFE, 24'hFF8001, 24'h007FFE},
    {1'b0, 2'b01, 1'b0, 6'd32, 24'h080000, 24'h012345, 24'hF80000, 24'h012345},
    {1'b0, 2'b10, 1'b1, 6'd32, 24'h800001, 24'h7FFFFF, 24'h800001, 24'h7FFFFF},
    {1'b0, 2'b11, 1'b0, 6'd24, 24'hC35A96, 24'h3C5A69, 24'hC35A96, 24'h3C5A69},
    {1'b1, 2'b00, 1'b0, 6'd32, 24'hABFFFF, 24'h000100, 24'hFFFFFF, 24'h000100},
    {1'b1, 2'b01, 1'b1, 6'd32, 24'h07ABCD, 24'h0C0003, 24'h07ABCD, 24'hFC0003},
    {1'b1, 2'b10, 1'b0, 6'd32, 24'hF00F0F, 24'h0F0FF0, 24'hF00F0F, 24'h0F0FF0},
    {1'b1, 2'b11, 1'b1, 6'd25, 24'h924924, 24'h6DB6DB, 24'h924924, 24'h6DB6DB},
    {1'b0, 2'b00, 1'b1, 6'd16, 24'h001234, 24'h00FEDC, 24'h001234, 24'hFFFEDC}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        wclk = 1'b0, sd = 1'b0;
  logic        i2s = 1'b0, swap = 1'b0, zen = 1'b0;
  logic [1:0]  wl = 2'b00;
  logic [23:0] left, right;
  logic        pair_valid, zero_flag, force_zero;

  int checks = 0, errors = 0;
  int vcnt = 0, vdouble = 0, zhigh = 0;
  logic        prev_v = 1'b0;
  logic [23:0] got_l = '0, got_r = '0;

  always #2 clk = ~clk;

  serial_audio_rx #(.ZERO_RUN(RUN)) dut_i (
    .bclk_i       (clk),
    .rst_i        (rst),
    .wclk_i       (wclk),
    .sdata_i      (sd),
    .cfg_i2s_i    (i2s),
    .cfg_wlen_i   (wl),
    .cfg_lr_swap_i(swap),
    .cfg_zdet_en_i(zen),
    .left_o       (left),
    .right_o      (right),
    .pair_valid_o (pair_valid),
    .zero_flag_o  (zero_flag),
    .force_zero_o (force_zero)
  );

  always @(negedge clk) begin
    if (pair_valid) begin
      vcnt++;
      got_l = left;
      got_r = right;
      if (prev_v) vdouble++;
    end
    prev_v = pair_valid;
    if (zero_flag) zhigh++;
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic d);
    @(negedge clk);
    wclk = w;
    sd   = d;
  endtask

  function automatic int len_of(input logic [1:0] code);
    // R2: 00 -> 16, 01 -> 20, 10 and 11 -> 24
    if (code == 2'b00) return 16;
    if (code == 2'b01) return 20;
    return 24;
  endfunction

  task automatic send_slot(input logic lvl, input logic fmt, input int n,
                           input logic [23:0] word, input int slot);
    for (int i = 0; i < slot; i++) begin
      logic b;
      b = 1'b1;
      if (!fmt && i >= slot - n) b = word[n - 1 - (i - (slot - n))];
      if (fmt && i >= 1 && i <= n) b = word[n - i];
      drive(lvl, b);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [105:0] v;
    int n, vb, zb;
    logic lvl_l;

    // R10: state during reset
    repeat (5) @(negedge clk);
    chk("R10 left at reset", left, 24'h0);
    chk("R10 right at reset", right, 24'h0);
    chk("R10 valid at reset", {23'h0, pair_valid}, 24'h0);
    chk("R10 flag at reset", {23'h0, zero_flag}, 24'h0);
    chk("R10 force at reset", {23'h0, force_zero}, 24'h0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      @(negedge clk);
      i2s  = v[105];
      wl   = v[104:103];
      swap = v[102];
      n     = len_of(v[104:103]);
      lvl_l = !v[102];  // R5: swap low means high word clock is left
      send_slot(!lvl_l, v[105], n, 24'hFFFFFF, 8);
      send_slot(lvl_l, v[105], n, v[95:72], int'(v[101:96]));
      vb = vcnt;
      send_slot(!lvl_l, v[105], n, v[71:48], int'(v[101:96]));
      repeat (7) drive(lvl_l, 1'b0);
      chk($sformatf("R6 vec%0d pair strobe", k), {23'h0, vcnt > vb}, 24'h1);
      chk($sformatf("%s R1 R2 R5 vec%0d left", v[105] ? "R4" : "R3", k), got_l, v[47:24]);
      chk($sformatf("%s R1 R2 R5 vec%0d right", v[105] ? "R4" : "R3", k), got_r, v[23:0]);
    end

    // R6: continuous I2S stream, one strobe per frame, single-cycle pulses
    @(negedge clk);
    i2s = 1'b1; wl = 2'b00; swap = 1'b0;
    send_slot(1'b0, 1'b1, 16, 24'hFFFFFF, 8);
    vb = vcnt;
    zb = vdouble;
    for (int f = 0; f < 3; f++) begin
      send_slot(1'b1, 1'b1, 16, 24'h001111 * (f + 1), 20);
      send_slot(1'b0, 1'b1, 16, 24'h000F0F + f, 20);
    end
    repeat (7) drive(1'b1, 1'b0);
    chk("R6 three frames three strobes", 24'(vcnt - vb), 24'd3);
    chk("R6 no stretched strobe", 24'(vdouble - zb), 24'd0);
    chk("R6 last left", got_l, 24'h003333);
    chk("R6 last right", got_r, 24'h000F11);

    // zero-run detector
    @(negedge clk);
    i2s = 1'b0; zen = 1'b1;
    drive(1'b1, 1'b1);
    zb = zhigh;
    repeat (RUN - 1) drive(1'b1, 1'b0);
    repeat (4) drive(1'b1, 1'b1);
    chk("R7 one zero short keeps flag low", 24'(zhigh - zb), 24'd0);

    repeat (RUN) drive(1'b1, 1'b0);
    repeat (3) drive(1'b1, 1'b0);
    chk("R7 flag after full run", {23'h0, zero_flag}, 24'h1);
    chk("R8 force with enable", {23'h0, force_zero}, 24'h1);

    zen = 1'b0;
    repeat (2) drive(1'b1, 1'b0);
    chk("R8 flag stays without enable", {23'h0, zero_flag}, 24'h1);
    chk("R8 force dropped without enable", {23'h0, force_zero}, 24'h0);

    zen = 1'b1;
    repeat (3) drive(1'b1, 1'b1);
    chk("R9 nonzero drops flag", {23'h0, zero_flag}, 24'h0);
    chk("R9 nonzero drops force", {23'h0, force_zero}, 24'h0);

    zb = zhigh;
    repeat (RUN - 1) drive(1'b1, 1'b0);
    repeat (4) drive(1'b1, 1'b1);
    chk("R9 counter cleared after saturation", 24'(zhigh - zb), 24'd0);

    // R10: reset clears a raised flag and held samples
    repeat (RUN + 3) drive(1'b1, 1'b0);
    chk("R7 flag raised before reset", {23'h0, zero_flag}, 24'h1);
    rst = 1'b1;
    repeat (2) drive(1'b1, 1'b0);
    chk("R10 flag cleared", {23'h0, zero_flag}, 24'h0);
    chk("R10 force cleared", {23'h0, force_zero}, 24'h0);
    chk("R10 left cleared", left, 24'h0);
    chk("R10 right cleared", right, 24'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule